// File: doc/BRIEF.md
# Operand Address Generator with Real-Mode Segmentation and Canonical Check

This block turns the address fields of one memory operand into the address that goes to memory. A request gives the operating mode, the base and index register values with their enables, a scale code, a sized displacement, a segment override code, the four segment register values, the next-instruction pointer, the state of the address-bit-20 gate and a flag that marks a stack access. The block forms the address combinationally and registers it. A valid strobe rises one cycle after the request strobe.

In 16-bit real mode the effective offset wraps at 64 KiB. The block then adds the chosen segment value shifted left by four bits, which gives a 21-bit result. When the bit-20 gate is closed, bit 20 is forced low. In 32-bit flat mode the result is the 32-bit base, scaled index and displacement sum. In 64-bit mode the block uses the full 64-bit sum, or the instruction pointer plus a 32-bit signed displacement. It then checks that bits 63 down to 47 all match. A result that fails this check raises a stack fault for a stack access and a general-protection fault for any other access. Paging, segment limits and privilege checks belong to other blocks.

Top module: `opaddr_gen`

## Requirements
- R1: During and right after a synchronous active-low reset, `addr_valid`, `addr`, `gp_fault` and `ss_fault` are all zero.
- R2: `addr_valid` is high in the cycle after every cycle where `req_valid` is high, and low otherwise. `addr`, `gp_fault` and `ss_fault` are registered together with it.
- R3: With `mode` = 0 (real), `addr` = (segment << 4) + offset[15:0]. The offset is the base, scaled index and displacement sum taken modulo 2^16. The result is zero-extended from 21 bits, so `addr[63:21]` is zero.
- R4: In real mode with `a20_en` = 0, `addr[20]` is 0. With `a20_en` = 1, bit 20 is kept.
- R5: The segment is chosen by `seg_ovr`: 1 = ES, 2 = CS, 3 = SS, 4 = DS. Codes 0 and 5 to 7 select the default segment, which is SS when `base_en` and `base_stk` are both 1 and DS otherwise.
- R6: With `mode` = 1 (flat), `addr` = (base if `base_en`) + (index << `scale`, if `index_en`) + displacement, truncated to 32 bits and zero-extended. The `scale` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R7: `disp_size` = 0 adds no displacement. 1 adds `disp[7:0]` sign-extended. 2 and 3 add `disp[31:0]` sign-extended.
- R8: With `mode` = 2 or 3 (64-bit), `addr` is the 64-bit sum. When `rip_rel` = 1, `addr` = `rip` + `disp[31:0]` sign-extended instead, and the base, index and `disp_size` inputs are ignored. `rip_rel` has no effect in the other modes.
- R9: In 64-bit mode, a result whose bits 63:48 are not all equal to bit 47 raises `ss_fault` when `stack_acc` = 1 and `gp_fault` otherwise. Both flags stay low for canonical results and in the other modes, and the two are never high together.
- R10: In a cycle without a request, `addr` and both fault flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe: the other inputs are sampled on this cycle |
| mode | input | 2 | 0 real 16-bit, 1 flat 32-bit, 2 or 3 64-bit |
| base_val | input | 64 | Base register value |
| base_en | input | 1 | A base register is present |
| base_stk | input | 1 | The base register is a frame or stack pointer |
| index_val | input | 64 | Index register value |
| index_en | input | 1 | An index register is present |
| scale | input | 2 | Index shift amount (x1, x2, x4, x8) |
| disp | input | 32 | Displacement |
| disp_size | input | 2 | 0 none, 1 eight-bit, 2 or 3 thirty-two-bit |
| rip_rel | input | 1 | Instruction-pointer-relative access (64-bit mode) |
| rip | input | 64 | Address of the next instruction |
| seg_ovr | input | 3 | Segment override code |
| seg_es | input | 16 | ES segment value |
| seg_cs | input | 16 | CS segment value |
| seg_ss | input | 16 | SS segment value |
| seg_ds | input | 16 | DS segment value |
| a20_en | input | 1 | Address bit 20 gate open |
| stack_acc | input | 1 | The access is a stack access |
| addr_valid | output | 1 | Result valid, one cycle after the request |
| addr | output | 64 | Computed address |
| gp_fault | output | 1 | Non-canonical, non-stack access |
| ss_fault | output | 1 | Non-canonical stack access |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before the first request, and that every input is stable around the sampling edge. They make no assumption about the data values, so any base, index, displacement or segment pattern is legal. The stimulus drives all inputs on the falling edge and holds reset low for several cycles. In half of the 64-bit cases it builds the base and index as sign-extended 48-bit and 32-bit values, so that canonical and non-canonical results both occur, and it crosses unused override codes and both `a20_en` states with random segments.

// File: rtl/opaddr_pkg.sv
// Package: shared encodings for the operand address generator.
// Assumes: the mode and override codes below are the contract with the decoder.
package opaddr_pkg;

    // Operating mode codes; code 3 is handled like 64-bit mode.
    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_FLAT = 2'd1,
        MODE_LONG = 2'd2,
        MODE_LALT = 2'd3
    } addr_mode_e;

    // Segment override codes; unlisted codes fall back to the default.
    typedef enum logic [2:0] {
        OVR_NONE = 3'd0,
        OVR_ES   = 3'd1,
        OVR_CS   = 3'd2,
        OVR_SS   = 3'd3,
        OVR_DS   = 3'd4
    } seg_ovr_e;

    // Displacement size codes.
    localparam logic [1:0] DSZ_NONE = 2'd0;
    localparam logic [1:0] DSZ_8    = 2'd1;

    // True for both 64-bit mode codes.
    function automatic logic is_long(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/opaddr_seg_select.sv
// Module: segment value selection for real-mode addressing.
// Does: picks the overridden segment, or SS for a stack-pointer base, else DS.
// Assumes: override codes follow opaddr_pkg::seg_ovr_e; others mean "none".
module opaddr_seg_select #(
    parameter int SEGW = 16
) (
    input  logic [2:0]      seg_ovr,
    input  logic            base_en,
    input  logic            base_stk,
    input  logic [SEGW-1:0] seg_es,
    input  logic [SEGW-1:0] seg_cs,
    input  logic [SEGW-1:0] seg_ss,
    input  logic [SEGW-1:0] seg_ds,
    output logic [SEGW-1:0] seg_out,
    output logic            used_ss
);
    import opaddr_pkg::*;

    logic default_ss;

    // Purpose: default segment follows the base register kind.
    always_comb default_ss = base_en && base_stk;

    // Purpose: apply the override, else the default segment.
    always_comb begin
        case (seg_ovr)
            OVR_ES:  begin seg_out = seg_es; used_ss = 1'b0; end
            OVR_CS:  begin seg_out = seg_cs; used_ss = 1'b0; end
            OVR_SS:  begin seg_out = seg_ss; used_ss = 1'b1; end
            OVR_DS:  begin seg_out = seg_ds; used_ss = 1'b0; end
            default: begin
                seg_out = default_ss ? seg_ss : seg_ds;
                used_ss = default_ss;
            end
        endcase
    end

    // R5: a stack-pointer base without an override always lands on SS.
    always_comb begin
        if ((seg_ovr == 3'd0) && base_en && base_stk)
            assert_default_ss_R5: assert (seg_out == seg_ss);
    end

endmodule

// File: rtl/opaddr_offset_sum.sv
// Module: effective offset adder.
// Does: base + (index << scale) + sized displacement, or rip + 32-bit displacement.
// Assumes: the caller decides when instruction-pointer-relative form applies.
module opaddr_offset_sum #(
    parameter int AW = 64,
    parameter int DW = 32
) (
    input  logic [AW-1:0] base_val,
    input  logic          base_en,
    input  logic [AW-1:0] index_val,
    input  logic          index_en,
    input  logic [1:0]    scale,
    input  logic [DW-1:0] disp,
    input  logic [1:0]    disp_size,
    input  logic          use_rip,
    input  logic [AW-1:0] rip,
    output logic [AW-1:0] sum
);
    import opaddr_pkg::*;

    localparam int BYTEW = 8;

    logic [AW-1:0] disp_b;
    logic [AW-1:0] disp_w;
    logic [AW-1:0] disp_sel;
    logic [AW-1:0] base_term;
    logic [AW-1:0] index_term;

    // Purpose: sign-extend both displacement sizes to the address width.
    always_comb begin
        disp_b = {{(AW-BYTEW){disp[BYTEW-1]}}, disp[BYTEW-1:0]};
        disp_w = {{(AW-DW){disp[DW-1]}}, disp};
    end

    // Purpose: pick the displacement by its size code.
    always_comb begin
        case (disp_size)
            DSZ_NONE: disp_sel = '0;
            DSZ_8:    disp_sel = disp_b;
            default:  disp_sel = disp_w;
        endcase
    end

    // Purpose: gate the register terms and scale the index.
    always_comb begin
        base_term  = base_en  ? base_val : '0;
        index_term = index_en ? (index_val << scale) : '0;
    end

    // Purpose: final three-input sum or instruction-pointer-relative sum.
    always_comb begin
        if (use_rip) sum = rip + disp_w;
        else         sum = base_term + index_term + disp_sel;
    end

    // R7: without base, index or displacement the offset is zero.
    always_comb begin
        if (!use_rip && !base_en && !index_en && disp_size == DSZ_NONE)
            assert_empty_zero_R7: assert (sum == '0);
    end

endmodule

// File: rtl/opaddr_canon_check.sv
// Module: canonical-form check of a wide address.
// Does: flags an address whose bits above VA-1 do not all copy bit VA-1.
// Assumes: VA <= AW; if VA == AW every address is canonical.
module opaddr_canon_check #(
    parameter int AW = 64,
    parameter int VA = 48
) (
    input  logic [AW-1:0] addr_in,
    output logic          noncanon
);
    generate
        if (VA >= AW) begin : g_full
            // Purpose: full-width virtual space, nothing to check.
            always_comb noncanon = 1'b0;
        end else begin : g_check
            localparam int TOPW = AW - VA + 1;
            logic [TOPW-1:0] top;
            // Purpose: sign bit and all bits above it must match.
            always_comb begin
                top      = addr_in[AW-1:VA-1];
                noncanon = !((top == '0) || (top == '1));
            end
        end
    endgenerate
endmodule

// File: rtl/opaddr_gen.sv
// Module: operand address generator (top).
// Does: forms a real-mode, flat or 64-bit address for one operand, checks
//       64-bit results for canonical form and registers the result with a
//       valid strobe one cycle after the request.
// Assumes: synchronous active-low reset; inputs are sampled only with req_valid.
module opaddr_gen #(
    parameter int AW   = 64,
    parameter int DW   = 32,
    parameter int SEGW = 16,
    parameter int OFFW = 16,
    parameter int FLW  = 32,
    parameter int VA   = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      mode,
    input  logic [AW-1:0]   base_val,
    input  logic            base_en,
    input  logic            base_stk,
    input  logic [AW-1:0]   index_val,
    input  logic            index_en,
    input  logic [1:0]      scale,
    input  logic [DW-1:0]   disp,
    input  logic [1:0]      disp_size,
    input  logic            rip_rel,
    input  logic [AW-1:0]   rip,
    input  logic [2:0]      seg_ovr,
    input  logic [SEGW-1:0] seg_es,
    input  logic [SEGW-1:0] seg_cs,
    input  logic [SEGW-1:0] seg_ss,
    input  logic [SEGW-1:0] seg_ds,
    input  logic            a20_en,
    input  logic            stack_acc,
    output logic            addr_valid,
    output logic [AW-1:0]   addr,
    output logic            gp_fault,
    output logic            ss_fault
);
    import opaddr_pkg::*;

    localparam int SHIFT = 4;
    localparam int RW    = SEGW + SHIFT + 1;   // real-mode result width
    localparam int GATEB = RW - 1;             // gated address bit
    localparam int TOPW  = AW - VA + 1;

    logic            long_m;
    logic            use_rip;
    logic [AW-1:0]   sum;
    logic [SEGW-1:0] seg_val;
    logic            seg_is_ss;
    logic [RW-1:0]   real_lin;
    logic [RW-1:0]   real_gated;
    logic [AW-1:0]   addr_next;
    logic            noncanon;
    logic            gp_next;
    logic            ss_next;

    // Purpose: mode decode and instruction-pointer-relative enable.
    always_comb begin
        long_m  = is_long(mode);
        use_rip = long_m && rip_rel;
    end

    opaddr_offset_sum #(.AW(AW), .DW(DW)) u_sum (
        .base_val (base_val),
        .base_en  (base_en),
        .index_val(index_val),
        .index_en (index_en),
        .scale    (scale),
        .disp     (disp),
        .disp_size(disp_size),
        .use_rip  (use_rip),
        .rip      (rip),
        .sum      (sum)
    );

    opaddr_seg_select #(.SEGW(SEGW)) u_seg (
        .seg_ovr (seg_ovr),
        .base_en (base_en),
        .base_stk(base_stk),
        .seg_es  (seg_es),
        .seg_cs  (seg_cs),
        .seg_ss  (seg_ss),
        .seg_ds  (seg_ds),
        .seg_out (seg_val),
        .used_ss (seg_is_ss)
    );

    opaddr_canon_check #(.AW(AW), .VA(VA)) u_canon (
        .addr_in (sum),
        .noncanon(noncanon)
    );

    // Purpose: real-mode segment shift plus 16-bit wrapped offset, then gate.
    always_comb begin
        real_lin   = {1'b0, seg_val, {SHIFT{1'b0}}} + {{(RW-OFFW){1'b0}}, sum[OFFW-1:0]};
        real_gated = real_lin;
        if (!a20_en) real_gated[GATEB] = 1'b0;
    end

    // Purpose: per-mode address and fault selection.
    always_comb begin
        gp_next = 1'b0;
        ss_next = 1'b0;
        case (mode)
            MODE_REAL: addr_next = {{(AW-RW){1'b0}}, real_gated};
            MODE_FLAT: addr_next = {{(AW-FLW){1'b0}}, sum[FLW-1:0]};
            default: begin
                addr_next = sum;
                gp_next   = noncanon && !stack_acc;
                ss_next   = noncanon && stack_acc;
            end
        endcase
    end

    // Purpose: output register stage with valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr       <= '0;
            gp_fault   <= 1'b0;
            ss_fault   <= 1'b0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid) begin
                addr     <= addr_next;
                gp_fault <= gp_next;
                ss_fault <= ss_next;
            end
        end
    end

    // R2: valid strobe follows the request by exactly one cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);

    // R3: real-mode results never reach past bit 20.
    assert_real_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == MODE_REAL) |=> (addr[AW-1:RW] == '0));

    // R4: closed gate clears the wrap bit.
    assert_a20_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == MODE_REAL && !a20_en) |=> !addr[GATEB]);

    // R6: flat results are zero-extended and never fault.
    assert_flat_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == MODE_FLAT) |=> (addr[AW-1:FLW] == '0 && !gp_fault && !ss_fault));

    // R9: fault flags agree with the registered 64-bit address.
    assert_canon_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && long_m) |=>
            ((gp_fault || ss_fault) == !((addr[AW-1:VA-1] == {TOPW{1'b0}}) || (addr[AW-1:VA-1] == {TOPW{1'b1}}))));
    assert_fault_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stack_acc) |=> !ss_fault);
    assert_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gp_fault && ss_fault));

    // R10: outputs hold while no request arrives.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(addr) && $stable(gp_fault) && $stable(ss_fault)));

endmodule

// File: tb/opaddr_gen_test.sv
module opaddr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [63:0] base_val = '0;
    logic        base_en = 1'b0;
    logic        base_stk = 1'b0;
    logic [63:0] index_val = '0;
    logic        index_en = 1'b0;
    logic [1:0]  scale = 2'd0;
    logic [31:0] disp = '0;
    logic [1:0]  disp_size = 2'd0;
    logic        rip_rel = 1'b0;
    logic [63:0] rip = '0;
    logic [2:0]  seg_ovr = 3'd0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic        a20_en = 1'b1;
    logic        stack_acc = 1'b0;
    logic        addr_valid;
    logic [63:0] addr;
    logic        gp_fault, ss_fault;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    opaddr_gen uut (.*);

    // Expected address from the requirements.
    function automatic logic [63:0] exp_disp();
        case (disp_size)
            2'd0: return 64'd0;
            2'd1: return {{56{disp[7]}}, disp[7:0]};
            default: return {{32{disp[31]}}, disp};
        endcase
    endfunction

    function automatic logic [15:0] exp_seg();
        case (seg_ovr)
            3'd1: return seg_es;
            3'd2: return seg_cs;
            3'd3: return seg_ss;
            3'd4: return seg_ds;
            default: return (base_en && base_stk) ? seg_ss : seg_ds;
        endcase
    endfunction

    function automatic logic [63:0] exp_sum();
        logic [63:0] s;
        s = exp_disp();
        if (base_en)  s = s + base_val;
        if (index_en) s = s + (index_val * (64'd1 << scale));
        return s;
    endfunction

    function automatic logic [63:0] exp_addr();
        logic [63:0] s;
        if (mode == 2'd0) begin
            s = ({48'd0, exp_seg()} * 64'd16) + {48'd0, exp_sum()[15:0]};
            if (!a20_en) s[20] = 1'b0;
            return s;
        end
        if (mode == 2'd1) return {32'd0, exp_sum()[31:0]};
        if (rip_rel) return rip + {{32{disp[31]}}, disp};
        return exp_sum();
    endfunction

    function automatic logic exp_noncanon();
        logic [63:0] a;
        if (mode[1] == 1'b0) return 1'b0;
        a = exp_addr();
        return !(a[63:47] == 17'h0 || a[63:47] == 17'h1FFFF);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Issue one request and check the registered result.
    task automatic run_req(input string req);
        logic [63:0] ea;
        logic        nc;
        ea = exp_addr();
        nc = exp_noncanon();
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, {63'd0, addr_valid}, 64'd1);
        check({req, " addr"}, addr, ea);
        check({req, " gp"}, {63'd0, gp_fault}, {63'd0, nc && !stack_acc});
        check({req, " ss"}, {63'd0, ss_fault}, {63'd0, nc && stack_acc});
    endtask

    task automatic clear_fields();
        base_en = 0; index_en = 0; base_stk = 0; disp_size = 0; rip_rel = 0;
        seg_ovr = 0; stack_acc = 0; a20_en = 1; scale = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'h5EED_0A11));
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 valid", {63'd0, addr_valid}, 64'd0);
        check("R1 addr", addr, 64'd0);
        check("R1 faults", {62'd0, gp_fault, ss_fault}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {63'd0, addr_valid}, 64'd0);

        // R3/R4: wrap beyond 1 MiB
        clear_fields(); mode = 0; seg_ds = 16'hFFFF; base_en = 1; base_val = 64'h10;
        run_req("R3 ffff:0010 gate open");
        check("R3 value", addr, 64'h100000);
        a20_en = 0;
        run_req("R4 ffff:0010 gate closed");
        check("R4 value", addr, 64'h0);
        // R3 offset wraps at 64 KiB
        clear_fields(); seg_ds = 16'h1000; base_en = 1; base_val = 64'hFFFF; disp_size = 1; disp = 32'h02;
        run_req("R3 offset wrap");
        check("R3 wrap value", addr, 64'h10001);
        // R5 override and defaults
        clear_fields(); seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000; seg_es = 16'h5000;
        base_en = 1; base_val = 64'h4; seg_ovr = 3'd2;
        run_req("R5 CS override");
        check("R5 CS value", addr, 64'h20004);
        seg_ovr = 0; base_stk = 1;
        run_req("R5 default SS");
        check("R5 SS value", addr, 64'h30004);
        seg_ovr = 3'd6;
        run_req("R5 unused code");
        check("R5 unused value", addr, 64'h30004);
        // R6/R7 flat with scale 8 and negative byte displacement
        clear_fields(); mode = 1; base_en = 1; base_val = 64'hFFFF_FFFF_0000_1000;
        index_en = 1; index_val = 64'h10; scale = 3; disp_size = 1; disp = 32'hFFFF_FFF0;
        run_req("R6 flat scaled");
        check("R7 flat value", addr, 64'h1070);
        rip_rel = 1;
        run_req("R8 rip ignored in flat");
        // R8 rip relative
        clear_fields(); mode = 2; rip_rel = 1; rip = 64'h0000_1000_0000_0000;
        disp = 32'h8000_0000; base_en = 1; base_val = 64'hDEAD;
        run_req("R8 rip relative");
        check("R8 value", addr, 64'h0000_0FFF_8000_0000);
        // R9 boundaries
        clear_fields(); mode = 2; base_en = 1;
        base_val = 64'h0000_7FFF_FFFF_FFFF; run_req("R9 top canonical");
        base_val = 64'h0000_8000_0000_0000; run_req("R9 gp fault");
        check("R9 gp raised", {63'd0, gp_fault}, 64'd1);
        stack_acc = 1; run_req("R9 ss fault");
        check("R9 ss raised", {63'd0, ss_fault}, 64'd1);
        base_val = 64'hFFFF_8000_0000_0000; mode = 3; run_req("R9 low canonical");
        // R10 hold
        held = addr;
        base_val = 64'h1234; @(negedge clk); @(negedge clk);
        check("R10 hold addr", addr, held);
        check("R2 idle valid", {63'd0, addr_valid}, 64'd0);

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            mode      = 2'($urandom_range(0, 3));
            base_en   = 1'($urandom);
            base_stk  = 1'($urandom);
            index_en  = 1'($urandom);
            scale     = 2'($urandom);
            disp      = $urandom;
            disp_size = 2'($urandom);
            rip_rel   = 1'($urandom);
            rip       = {$urandom, $urandom};
            seg_ovr   = 3'($urandom);
            seg_es = 16'($urandom); seg_cs = 16'($urandom);
            seg_ss = 16'($urandom); seg_ds = 16'($urandom);
            a20_en    = 1'($urandom);
            stack_acc = 1'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                base_val  = {$urandom, $urandom};
                index_val = {$urandom, $urandom};
            end else begin
                logic [47:0] b48;
                logic [31:0] i32;
                b48 = {16'($urandom), $urandom};
                i32 = $urandom;
                base_val  = {{16{b48[47]}}, b48};
                index_val = {{32{i32[31]}}, i32};
                rip       = {{16{b48[46]}}, b48[46:0], 1'b0};
            end
            run_req("R2-random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule